// File: doc/BRIEF.md
# Serial Panel Register Write Sequencer

This block writes 16-bit values into the 8-bit-addressed control registers of a display panel over a write-only SPI link in mode 3. Each register write goes out as two separate 24-bit transfers, each with its own chip-select low window. The first transfer carries a selector byte, a zero byte and the register number. The second carries a data selector byte and then the 16-bit value, most significant byte first.

A host starts a write with a request pulse and gets a busy level and a one-cycle done pulse back. The host sets the SCK rate with a half-period divider, and the block enforces a floor on that divider. A boot input runs a fixed power-on sequence of two writes. The first write switches the panel on through its shutdown register. The second programs the driver-output register with a scan configuration taken from a 4-bit input.

Top module: `panel_spi_writer`

## Requirements
- R1: Each write begins with an index transfer. Chip select goes low, exactly 24 bits are clocked MSB first as 0x74, 0x00 and the register number, and then chip select goes high.
- R2: The data transfer follows in its own chip-select window as 0x76, then the value's high byte, then its low byte.
- R3: The link runs in SPI mode 3. SCK is high whenever chip select is high. MOSI changes only on falling SCK edges and holds steady while SCK is high.
- R4: Every SCK half-period lasts H clock cycles, where H is `half_div_i`, raised to MIN_HALF (default 3) when smaller. The transfer starts with one half-period with SCK high and chip select low. Then each bit gets one low half and one high half.
- R5: Chip select stays high for at least two half-periods (one SCK period) between two transfers.
- R6: `busy_o` rises in the cycle after a request is accepted. For a host write, `busy_o` falls in the same cycle that `done_o` rises. `done_o` lasts exactly one cycle and comes one cycle after the data transfer's chip-select-high time ends. A new request is accepted in the cycle `done_o` is high.
- R7: A request or boot pulse that arrives while `busy_o` is high is ignored and produces no transfer.
- R8: A boot pulse writes 0x0000 to register 0x11 (panel on) and then writes register 0x01. `busy_o` stays high from the boot pulse until the second write's done cycle, and `done_o` pulses after each of the two writes.
- R9: The value written to register 0x01 is 0x00EF with these bits ORed in: bit 8 from `scan_cfg_i[0]` (left-to-right), bit 9 from `scan_cfg_i[1]` (top-to-bottom), bit 11 from `scan_cfg_i[2]` (BGR order), and bit 13 from `scan_cfg_i[3]` (normal output).
- R10: If a boot pulse and a host request arrive in the same idle cycle, the boot sequence runs and the host request is dropped.
- R11: During and right after reset, chip select and SCK are high and `busy_o` and `done_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| half_div_i | input | DIV_W | SCK half-period in clock cycles (floored at MIN_HALF), held stable while busy |
| wr_req_i | input | 1 | Host write request, sampled when idle |
| wr_addr_i | input | 8 | Register number for the host write |
| wr_data_i | input | 16 | Value for the host write |
| boot_i | input | 1 | Start the power-on write sequence |
| scan_cfg_i | input | 4 | Scan configuration for the driver-output write |
| busy_o | output | 1 | Write or boot sequence in progress |
| done_o | output | 1 | One-cycle pulse after each completed write |
| spi_sck_o | output | 1 | Serial clock, idle high |
| spi_mosi_o | output | 1 | Serial data out |
| spi_cs_n_o | output | 1 | Active-low chip select |

## Verification
Two events can land in the same cycle. The first is the end of one write, shown by the done cycle, and the acceptance of the next request. The second is a boot pulse and a host request arriving together. The bench raises a request in exactly the cycle it sees `done_o` high. In a separate test it drives `boot_i` and `wr_req_i` on the same edge. A behavioural model predicts every cycle of `busy_o`, `done_o` and the serial lines and is compared against the design on each clock. A serial monitor counts the transfers: only the boot frames may appear, and the chained write must follow without a lost cycle.

// File: rtl/panel_spi_pkg.sv
package panel_spi_pkg;

    localparam int          FRAME_BITS = 24;
    localparam logic [7:0]  SEL_INDEX  = 8'h74;
    localparam logic [7:0]  SEL_DATA   = 8'h76;
    localparam logic [7:0]  REG_SHUT   = 8'h11;
    localparam logic [7:0]  REG_DRIVE  = 8'h01;
    localparam logic [15:0] SHUT_ON    = 16'h0000;
    localparam logic [15:0] DRIVE_BASE = 16'h2AEF;
    localparam logic [15:0] DRIVE_MASK = 16'h2B00;

    typedef struct packed {
        logic [7:0]  addr;
        logic [15:0] value;
    } wr_req_t;

    typedef struct packed {
        logic normal;
        logic bgr;
        logic top_bottom;
        logic left_right;
    } scan_cfg_t;

    function automatic logic [FRAME_BITS-1:0] index_frame(logic [7:0] addr);
        return {SEL_INDEX, 8'h00, addr};
    endfunction

    function automatic logic [FRAME_BITS-1:0] data_frame(logic [15:0] value);
        return {SEL_DATA, value};
    endfunction

    function automatic logic [15:0] drive_value(scan_cfg_t c);
        logic [15:0] v;
        v     = DRIVE_BASE & ~DRIVE_MASK;
        v[8]  = c.left_right;
        v[9]  = c.top_bottom;
        v[11] = c.bgr;
        v[13] = c.normal;
        return v;
    endfunction

endpackage

// File: rtl/spi_frame_tx.sv
module spi_frame_tx
    import panel_spi_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start_i,
    input  logic [FRAME_BITS-1:0] frame_i,
    input  logic [DIV_W-1:0]      half_i,
    output logic                  sck_o,
    output logic                  mosi_o,
    output logic                  cs_n_o,
    output logic                  frame_done_o
);

    localparam int         BIT_W    = $clog2(FRAME_BITS);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(FRAME_BITS - 1);

    typedef enum logic [2:0] {F_IDLE, F_LEAD, F_LOW, F_HIGH, F_GAPA, F_GAPB} fstate_t;

    fstate_t               st;
    logic [FRAME_BITS-1:0] shreg;
    logic [BIT_W-1:0]      bitn;
    logic [DIV_W-1:0]      tcnt;
    logic                  sck_q, mosi_q, cs_n_q, fdone_q;
    logic                  phase_end;

    assign phase_end = (tcnt == half_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= F_IDLE;
            shreg   <= '0;
            bitn    <= '0;
            tcnt    <= DIV_W'(1);
            sck_q   <= 1'b1;
            mosi_q  <= 1'b0;
            cs_n_q  <= 1'b1;
            fdone_q <= 1'b0;
        end else begin
            fdone_q <= 1'b0;
            if (st == F_IDLE) begin
                tcnt <= DIV_W'(1);
                if (start_i) begin
                    st     <= F_LEAD;
                    cs_n_q <= 1'b0;
                    mosi_q <= frame_i[FRAME_BITS-1];
                    shreg  <= {frame_i[FRAME_BITS-2:0], 1'b0};
                    bitn   <= '0;
                end
            end else if (phase_end) begin
                tcnt <= DIV_W'(1);
                unique case (st)
                    F_LEAD: begin
                        sck_q <= 1'b0;
                        st    <= F_LOW;
                    end
                    F_LOW: begin
                        sck_q <= 1'b1;
                        st    <= F_HIGH;
                    end
                    F_HIGH: begin
                        if (bitn == LAST_BIT) begin
                            cs_n_q <= 1'b1;
                            st     <= F_GAPA;
                        end else begin
                            sck_q  <= 1'b0;
                            mosi_q <= shreg[FRAME_BITS-1];
                            shreg  <= {shreg[FRAME_BITS-2:0], 1'b0};
                            bitn   <= bitn + 1'b1;
                            st     <= F_LOW;
                        end
                    end
                    F_GAPA: st <= F_GAPB;
                    F_GAPB: begin
                        st      <= F_IDLE;
                        fdone_q <= 1'b1;
                    end
                    default: st <= F_IDLE;
                endcase
            end else begin
                tcnt <= tcnt + 1'b1;
            end
        end
    end

    assign sck_o        = sck_q;
    assign mosi_o       = mosi_q;
    assign cs_n_o       = cs_n_q;
    assign frame_done_o = fdone_q;

    // R3: clock parks high outside a transfer
    a_r3_sck_idle_high: assert property (@(posedge clk) disable iff (rst)
        cs_n_q |-> sck_q);

    // R3: data holds while the clock is high inside a transfer
    a_r3_mosi_held_high: assert property (@(posedge clk) disable iff (rst)
        (!cs_n_q && sck_q && $past(sck_q) && !$past(cs_n_q)) |-> $stable(mosi_q));

    // R1: chip select releases only after the last bit
    a_r1_frame_len: assert property (@(posedge clk) disable iff (rst)
        $rose(cs_n_q) |-> ($past(bitn) == LAST_BIT));

endmodule

// File: rtl/reg_write_ctrl.sv
module reg_write_ctrl
    import panel_spi_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  req_valid_i,
    input  wr_req_t               req_i,
    input  logic                  frame_done_i,
    output logic                  start_o,
    output logic [FRAME_BITS-1:0] frame_o,
    output logic                  busy_o,
    output logic                  done_o
);

    typedef enum logic [2:0] {C_IDLE, C_IDX, C_IDX_WAIT, C_DAT, C_DAT_WAIT} cstate_t;

    cstate_t st;
    wr_req_t held;
    logic    done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= C_IDLE;
            held   <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (st)
                C_IDLE: if (req_valid_i) begin
                    held <= req_i;
                    st   <= C_IDX;
                end
                C_IDX:      st <= C_IDX_WAIT;
                C_IDX_WAIT: if (frame_done_i) st <= C_DAT;
                C_DAT:      st <= C_DAT_WAIT;
                C_DAT_WAIT: if (frame_done_i) begin
                    st     <= C_IDLE;
                    done_q <= 1'b1;
                end
                default:    st <= C_IDLE;
            endcase
        end
    end

    assign start_o = (st == C_IDX) || (st == C_DAT);
    assign frame_o = (st == C_DAT) ? data_frame(held.value) : index_frame(held.addr);
    assign busy_o  = (st != C_IDLE);
    assign done_o  = done_q;

    // R6: done is a single-cycle pulse
    a_r6_done_one_cycle: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q);

    // R6: done follows the end of the data transfer
    a_r6_done_after_data: assert property (@(posedge clk) disable iff (rst)
        done_q |-> ($past(st) == C_DAT_WAIT && $past(frame_done_i)));

    // R7: the captured write cannot change while a write is in flight
    a_r7_hold_while_busy: assert property (@(posedge clk) disable iff (rst)
        (st != C_IDLE) |=> $stable(held));

endmodule

// File: rtl/boot_seq.sv
module boot_seq
    import panel_spi_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      start_i,
    input  logic      grant_i,
    input  logic      wr_done_i,
    input  scan_cfg_t scan_cfg_i,
    output logic      req_o,
    output wr_req_t   req_data_o,
    output logic      hold_o
);

    typedef enum logic [2:0] {B_IDLE, B_PEND1, B_RUN1, B_PEND2, B_RUN2} bstate_t;

    bstate_t st;

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= B_IDLE;
        end else begin
            unique case (st)
                B_IDLE:  if (start_i) st <= B_PEND1;
                B_PEND1: if (grant_i) st <= B_RUN1;
                B_RUN1:  if (wr_done_i) st <= B_PEND2;
                B_PEND2: if (grant_i) st <= B_RUN2;
                B_RUN2:  if (wr_done_i) st <= start_i ? B_PEND1 : B_IDLE;
                default: st <= B_IDLE;
            endcase
        end
    end

    always_comb begin
        req_o      = (st == B_PEND1) || (st == B_PEND2);
        req_data_o = (st == B_PEND1) ? '{addr: REG_SHUT,  value: SHUT_ON}
                                     : '{addr: REG_DRIVE, value: drive_value(scan_cfg_i)};
        hold_o     = (st != B_IDLE) && !((st == B_RUN2) && wr_done_i);
    end

    // R8: the driver-output write is only requested after the power-on write
    a_r8_order: assert property (@(posedge clk) disable iff (rst)
        (st == B_PEND2) |-> ($past(st) == B_RUN1 && $past(wr_done_i)));

endmodule

// File: rtl/panel_spi_writer.sv
module panel_spi_writer
    import panel_spi_pkg::*;
#(
    parameter int DIV_W    = 8,
    parameter int MIN_HALF = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] half_div_i,
    input  logic             wr_req_i,
    input  logic [7:0]       wr_addr_i,
    input  logic [15:0]      wr_data_i,
    input  logic             boot_i,
    input  logic [3:0]       scan_cfg_i,
    output logic             busy_o,
    output logic             done_o,
    output logic             spi_sck_o,
    output logic             spi_mosi_o,
    output logic             spi_cs_n_o
);

    localparam logic [DIV_W-1:0] MIN_H = DIV_W'(MIN_HALF);

    logic [DIV_W-1:0]      half_eff;
    logic                  ctrl_busy, ctrl_done, ctrl_start, frame_done;
    logic [FRAME_BITS-1:0] ctrl_frame;
    logic                  boot_req, boot_hold, boot_start, host_ok, req_valid;
    wr_req_t               boot_data, req_mux;

    assign half_eff   = (half_div_i < MIN_H) ? MIN_H : half_div_i;
    assign busy_o     = ctrl_busy | boot_hold;
    assign boot_start = boot_i & ~busy_o;
    assign host_ok    = wr_req_i & ~busy_o & ~boot_i;
    assign req_valid  = boot_req | host_ok;
    assign req_mux    = boot_req ? boot_data : '{addr: wr_addr_i, value: wr_data_i};
    assign done_o     = ctrl_done;

    boot_seq u_boot (
        .clk        (clk),
        .rst        (rst),
        .start_i    (boot_start),
        .grant_i    (boot_req & ~ctrl_busy),
        .wr_done_i  (ctrl_done),
        .scan_cfg_i (scan_cfg_t'(scan_cfg_i)),
        .req_o      (boot_req),
        .req_data_o (boot_data),
        .hold_o     (boot_hold)
    );

    reg_write_ctrl u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .req_valid_i  (req_valid),
        .req_i        (req_mux),
        .frame_done_i (frame_done),
        .start_o      (ctrl_start),
        .frame_o      (ctrl_frame),
        .busy_o       (ctrl_busy),
        .done_o       (ctrl_done)
    );

    spi_frame_tx #(.DIV_W(DIV_W)) u_tx (
        .clk          (clk),
        .rst          (rst),
        .start_i      (ctrl_start),
        .frame_i      (ctrl_frame),
        .half_i       (half_eff),
        .sck_o        (spi_sck_o),
        .mosi_o       (spi_mosi_o),
        .cs_n_o       (spi_cs_n_o),
        .frame_done_o (frame_done)
    );

    // R10: a boot pulse beats a simultaneous host request
    a_r10_boot_wins: assert property (@(posedge clk) disable iff (rst)
        (boot_i && wr_req_i && !busy_o) |=> (!ctrl_busy && boot_hold));

    // R6: busy rises in the cycle after a host request is taken
    a_r6_busy_on_accept: assert property (@(posedge clk) disable iff (rst)
        (wr_req_i && !busy_o) |=> busy_o);

endmodule

// File: tb/panel_spi_writer_test.sv
module panel_spi_writer_test;

    localparam int DIV_W    = 8;
    localparam int MIN_HALF = 3;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [DIV_W-1:0] half_div_i = '0;
    logic             wr_req_i = 1'b0;
    logic [7:0]       wr_addr_i = '0;
    logic [15:0]      wr_data_i = '0;
    logic             boot_i = 1'b0;
    logic [3:0]       scan_cfg_i = '0;
    logic             busy_o, done_o, spi_sck_o, spi_mosi_o, spi_cs_n_o;

    always #5 clk = ~clk;

    panel_spi_writer #(.DIV_W(DIV_W), .MIN_HALF(MIN_HALF)) uut (
        .clk(clk), .rst(rst), .half_div_i(half_div_i), .wr_req_i(wr_req_i),
        .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i), .boot_i(boot_i),
        .scan_cfg_i(scan_cfg_i), .busy_o(busy_o), .done_o(done_o),
        .spi_sck_o(spi_sck_o), .spi_mosi_o(spi_mosi_o), .spi_cs_n_o(spi_cs_n_o)
    );

    int checks = 0;
    int errors = 0;

    // expected per-cycle outputs: {busy, done, cs_n, sck, mosi}
    logic [4:0]  exp_q[$];
    logic [23:0] exp_frames[$];
    string       exp_tags[$];
    int          frames_seen = 0;
    int          cur_half = MIN_HALF;

    function automatic int half_of(int d);
        return (d < MIN_HALF) ? MIN_HALF : d;
    endfunction

    function automatic logic [15:0] drive_expect(logic [3:0] s);
        logic [15:0] v = 16'h00EF;
        if (s[0]) v = v | 16'h0100;
        if (s[1]) v = v | 16'h0200;
        if (s[2]) v = v | 16'h0800;
        if (s[3]) v = v | 16'h2000;
        return v;
    endfunction

    function automatic void push_frame(logic [23:0] f, int h, string tag);
        exp_frames.push_back(f);
        exp_tags.push_back(tag);
        for (int k = 0; k < h; k++) exp_q.push_back({1'b1, 1'b0, 1'b0, 1'b1, f[23]});
        for (int b = 23; b >= 0; b--) begin
            for (int k = 0; k < h; k++) exp_q.push_back({1'b1, 1'b0, 1'b0, 1'b0, f[b]});
            for (int k = 0; k < h; k++) exp_q.push_back({1'b1, 1'b0, 1'b0, 1'b1, f[b]});
        end
        for (int k = 0; k < 2 * h; k++) exp_q.push_back(5'b1_0_1_1_0);
    endfunction

    function automatic void push_write(logic [7:0] a, logic [15:0] v, int h,
                                       logic last_busy, string t_idx, string t_dat);
        exp_q.push_back(5'b1_0_1_1_0);
        push_frame({8'h74, 8'h00, a}, h, t_idx);
        exp_q.push_back(5'b1_0_1_1_0);
        exp_q.push_back(5'b1_0_1_1_0);
        push_frame({8'h76, v}, h, t_dat);
        exp_q.push_back(5'b1_0_1_1_0);
        exp_q.push_back({last_busy, 1'b1, 1'b1, 1'b1, 1'b0});
    endfunction

    // reference model: decides acceptance at each edge
    always @(posedge clk) begin
        if (rst) begin
            exp_q.delete();
        end else if (exp_q.size() == 0) begin
            int h;
            h = half_of(int'(half_div_i));
            if (boot_i) begin
                exp_q.push_back(5'b1_0_1_1_0);
                push_write(8'h11, 16'h0000, h, 1'b1, "R8", "R8");
                exp_q.push_back(5'b1_0_1_1_0);
                push_write(8'h01, drive_expect(scan_cfg_i), h, 1'b0, "R8", "R9");
            end else if (wr_req_i) begin
                push_write(wr_addr_i, wr_data_i, h, 1'b0, "R1", "R2");
            end
        end
    end

    // cycle-by-cycle comparison, plus chip-select gap measurement
    int  hi_cnt = 0;
    bit  seen_frame = 0;
    logic prev_cs = 1'b1;

    always @(negedge clk) begin
        if (!rst) begin
            logic [4:0] e;
            e = (exp_q.size() != 0) ? exp_q.pop_front() : 5'b0_0_1_1_0;
            checks++;
            if (busy_o !== e[4]) begin
                errors++;
                $display("FAIL R6 busy_o actual %b expected %b at %0t", busy_o, e[4], $time);
            end
            if (done_o !== e[3]) begin
                errors++;
                $display("FAIL R6 done_o actual %b expected %b at %0t", done_o, e[3], $time);
            end
            if (spi_cs_n_o !== e[2]) begin
                errors++;
                $display("FAIL R1 cs_n actual %b expected %b at %0t", spi_cs_n_o, e[2], $time);
            end
            if (spi_sck_o !== e[1]) begin
                errors++;
                $display("FAIL R4 sck actual %b expected %b at %0t", spi_sck_o, e[1], $time);
            end
            if (!e[2] && spi_mosi_o !== e[0]) begin
                errors++;
                $display("FAIL R1 mosi actual %b expected %b at %0t", spi_mosi_o, e[0], $time);
            end
            if (spi_cs_n_o && !spi_sck_o) begin
                errors++;
                $display("FAIL R3 sck low while idle actual 0 expected 1 at %0t", $time);
            end
            if (prev_cs && !spi_cs_n_o) begin
                if (seen_frame) begin
                    checks++;
                    if (hi_cnt < 2 * cur_half) begin
                        errors++;
                        $display("FAIL R5 cs high gap actual %0d expected >= %0d", hi_cnt, 2 * cur_half);
                    end
                end
                seen_frame = 1;
                hi_cnt = 0;
            end else if (spi_cs_n_o) begin
                hi_cnt++;
            end
            prev_cs = spi_cs_n_o;
        end
    end

    // serial monitor: samples on rising SCK while selected
    logic [23:0] mon_sh = '0;
    int          mon_n = 0;

    always @(negedge spi_cs_n_o) begin
        mon_n = 0;
        mon_sh = '0;
    end

    always @(posedge spi_sck_o) begin
        if (!rst && !spi_cs_n_o) begin
            mon_sh = {mon_sh[22:0], spi_mosi_o};
            mon_n++;
        end
    end

    always @(posedge spi_cs_n_o) begin
        if (!rst) begin
            logic [23:0] ef;
            string       tg;
            frames_seen++;
            checks++;
            if (mon_n != 24) begin
                errors++;
                $display("FAIL R1 bits per frame actual %0d expected 24", mon_n);
            end
            checks++;
            if (exp_frames.size() == 0) begin
                errors++;
                $display("FAIL R7 unexpected frame actual %h expected none", mon_sh);
            end else begin
                ef = exp_frames.pop_front();
                tg = exp_tags.pop_front();
                if (mon_sh !== ef) begin
                    errors++;
                    $display("FAIL %s frame actual %h expected %h", tg, mon_sh, ef);
                end
            end
        end
    end

    task automatic wait_idle();
        do @(negedge clk); while (exp_q.size() != 0 || busy_o);
        repeat (3) @(negedge clk);
    endtask

    task automatic host_write(logic [7:0] a, logic [15:0] v);
        @(negedge clk);
        wr_addr_i = a;
        wr_data_i = v;
        wr_req_i  = 1'b1;
        @(negedge clk);
        wr_req_i  = 1'b0;
    endtask

    task automatic check_count(string tag, int got, int want);
        checks++;
        if (got != want) begin
            errors++;
            $display("FAIL %s count actual %0d expected %0d", tag, got, want);
        end
    endtask

    task automatic set_div(int d);
        half_div_i = DIV_W'(d);
        cur_half   = half_of(d);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R6 watchdog actual hang expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int base;
        // R11: reset state
        repeat (3) @(negedge clk);
        check_count("R11 cs_n", int'(spi_cs_n_o), 1);
        check_count("R11 sck", int'(spi_sck_o), 1);
        check_count("R11 busy", int'(busy_o), 0);
        check_count("R11 done", int'(done_o), 0);
        rst = 1'b0;
        @(negedge clk);
        check_count("R11 busy after reset", int'(busy_o), 0);

        // R4: divider below the floor is raised to MIN_HALF
        set_div(0);
        host_write(8'h5A, 16'hC3A5);
        wait_idle();

        // R4: larger divider
        set_div(5);
        host_write(8'hFF, 16'h0001);
        wait_idle();

        // R7: requests and boot pulses during a write are ignored
        set_div(3);
        base = frames_seen;
        host_write(8'h33, 16'h8001);
        repeat (40) @(negedge clk);
        wr_addr_i = 8'h22; wr_req_i = 1'b1;
        @(negedge clk); wr_req_i = 1'b0;
        repeat (200) @(negedge clk);
        boot_i = 1'b1;
        @(negedge clk); boot_i = 1'b0;
        wait_idle();
        check_count("R7 frames", frames_seen - base, 2);

        // R6: a request in the done cycle is taken at once
        host_write(8'h10, 16'h1234);
        do @(negedge clk); while (!done_o);
        wr_addr_i = 8'h20; wr_data_i = 16'hABCD; wr_req_i = 1'b1;
        @(negedge clk);
        wr_req_i = 1'b0;
        check_count("R6 chained busy", int'(busy_o), 1);
        wait_idle();

        // R8, R9: boot sequence with a mixed scan configuration
        set_div(4);
        scan_cfg_i = 4'b1011;
        base = frames_seen;
        @(negedge clk); boot_i = 1'b1;
        @(negedge clk); boot_i = 1'b0;
        wait_idle();
        check_count("R8 frames", frames_seen - base, 4);

        // R10: boot and host request in the same cycle
        scan_cfg_i = 4'b0100;
        base = frames_seen;
        @(negedge clk);
        boot_i = 1'b1; wr_req_i = 1'b1; wr_addr_i = 8'h77; wr_data_i = 16'h5555;
        @(negedge clk);
        boot_i = 1'b0; wr_req_i = 1'b0;
        wait_idle();
        check_count("R10 frames", frames_seen - base, 4);

        check_count("R2 leftover frames", exp_frames.size(), 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule